// File: doc/BRIEF.md
# Scratchpad Write Controller with Per-Page Protection

This block sits behind a byte-level front end of a single-wire serial bus. It stages writes for a small paged nonvolatile array. A write command carries a 16-bit target address and a run of data bytes. The bytes land in an 8-byte staging row, starting at the offset that the low address bits select. The master then reads the row back, together with the stored address and an ending-offset/status byte. After that it issues a copy command that echoes the address and status. The copy commits the staged bytes to the array after a fixed programming delay.

Both the write and the read-back return an inverted CRC-16 that covers the whole transaction. The CRC is sent only once the transfer has reached the last byte of the row. Each of the four data pages can be locked against copies. A page can also be put in a one-way mode, in which staged bytes are merged as the AND of the new byte and the stored byte, so bits can only fall. A fourth command streams the array out for inspection.

Top module: `scp_write_ctrl`

## Requirements
- R1: After reset, `tx_valid` is 0 and `tx_data` is FFh. A read-back then returns target address 0000h, status 00h and eight zero bytes.
- R2: The command byte is the first byte after `bus_reset`. Command 3Ch (write) takes a low address byte, then a high address byte, then data bytes. These fill the row from offset addr[2:0] upward. Read-back (C3h) answers each `tx_req` with one `tx_data` byte one cycle later. The order is: address low, address high, status, then the row bytes from offset addr[2:0] to offset 7.
- R3: Status bits [2:0] hold the offset of the last data byte written. A write command clears status bits 7 and 5.
- R4: Data bytes that arrive after offset 7 has been written are ignored. Before offset 7 is written, a write transfer answers `tx_req` with FFh.
- R5: The CRC-16 uses x^16+x^15+x^2+1 and takes bytes LSB first from zero. It restarts at each bus reset. For a write it covers the command, address and data bytes; for a read-back it covers the command, address, status and data bytes. It is sent bit-inverted, low byte first.
- R6: After the two CRC bytes, every further `tx_req` returns FFh until the next bus reset.
- R7: In a one-way page (mode bit 1 set, bit 0 clear), each staged byte is the AND of the received byte and the stored byte at that address. Copies write the merged value.
- R8: A copy to a locked page (mode bit 0 set) is refused: it answers FFh and leaves the array unchanged. Page p takes `page_mode[2p+1:2p]` and spans addresses 32p to 32p+31.
- R9: Command 5Ah (copy) takes address low, address high and status. On an exact match it answers 00h while busy. COPY_CYC cycles after the status byte it writes offsets addr[2:0] through status[2:0] of the addressed row and sets status bit 7. After that it answers AAh.
- R10: A copy whose presented address or status differs from the stored values, or whose status bit 5 is set, answers FFh and leaves the array unchanged.
- R11: A bus reset with `bit_partial` high during a write data phase sets status bit 5.
- R12: Command A5h takes address low and high, then returns one array byte per `tx_req` at increasing addresses. It returns FFh past the last address (143). The array starts all FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset | input | 1 | Bus reset seen by the front end; ends the transaction |
| bit_partial | input | 1 | Qualifies `bus_reset`: a byte was cut short |
| rx_valid | input | 1 | A byte from the master is present |
| rx_data | input | 8 | Byte from the master |
| tx_req | input | 1 | Master wants the next byte |
| page_mode | input | 2*PAGES | Per-page mode: bit 0 lock, bit 1 one-way |
| tx_valid | output | 1 | `tx_data` holds the answer to last cycle's `tx_req` |
| tx_data | output | 8 | Byte to the master |

## Verification
The copy engine runs on its own counter and keeps running through bus resets. This means the programming write and a bus reset can land on the same clock edge. The bench provokes this by counting cycles from the status byte of a copy and pulsing `bus_reset` exactly on the edge where the row is committed. It then judges the outcome from the ports alone. A memory read of the row must show the new bytes, and a read-back must show status bit 7 set, even though the command state returned to idle in that same cycle.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam logic [7:0] CMD_WRITE = 8'h3C;
  localparam logic [7:0] CMD_READ  = 8'hC3;
  localparam logic [7:0] CMD_COPY  = 8'h5A;
  localparam logic [7:0] CMD_MREAD = 8'hA5;

  localparam int ES_PF = 5;
  localparam int ES_AA = 7;

  localparam logic [7:0] TX_IDLE = 8'hFF;
  localparam logic [7:0] TX_BUSY = 8'h00;
  localparam logic [7:0] TX_DONE = 8'hAA;

  typedef enum logic [3:0] {
    S_CMD, S_TA1, S_TA2, S_ES, S_WR, S_RD, S_CPY, S_MEM, S_TAIL
  } scp_state_e;
endpackage

// File: rtl/scp_crc16.sv
module scp_crc16 #(
  parameter logic [15:0] POLY_R = 16'hA001
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  function automatic logic [15:0] step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ POLY_R;
      else             r = r >> 1;
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || clr) crc <= '0;
    else if (en)    crc <= step(crc, din);
  end
endmodule

// File: rtl/scp_mem_model.sv
module scp_mem_model #(
  parameter int ROWS      = 18,
  parameter int ROW_BYTES = 8,
  localparam int MEM_BYTES = ROWS * ROW_BYTES,
  localparam int AW        = $clog2(MEM_BYTES),
  localparam int OFF_W     = $clog2(ROW_BYTES),
  localparam int RW        = AW - OFF_W
) (
  input  logic                   clk,
  input  logic                   we,
  input  logic [RW-1:0]          wr_row,
  input  logic [ROW_BYTES-1:0]   wr_mask,
  input  logic [8*ROW_BYTES-1:0] wr_data,
  input  logic [AW-1:0]          rd_addr,
  output logic [7:0]             rd_data
);
  logic [7:0] mem [MEM_BYTES];

  initial begin
    for (int i = 0; i < MEM_BYTES; i++) mem[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < ROW_BYTES; b++)
        if (wr_mask[b]) mem[{wr_row, OFF_W'(b)}] <= wr_data[8*b +: 8];
    end
  end

  assign rd_data = (int'(rd_addr) < MEM_BYTES) ? mem[rd_addr] : 8'hFF;

  AST_ROW_IN_RANGE: assert property (@(posedge clk) we |-> (int'(wr_row) < ROWS)); // R9
endmodule

// File: rtl/scp_write_ctrl.sv
module scp_write_ctrl
  import scp_pkg::*;
#(
  parameter int ROWS       = 18,
  parameter int ROW_BYTES  = 8,
  parameter int PAGES      = 4,
  parameter int PAGE_BYTES = 32,
  parameter int COPY_CYC   = 40
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_reset,
  input  logic               bit_partial,
  input  logic               rx_valid,
  input  logic [7:0]         rx_data,
  input  logic               tx_req,
  input  logic [2*PAGES-1:0] page_mode,
  output logic               tx_valid,
  output logic [7:0]         tx_data
);
  localparam int MEM_BYTES  = ROWS * ROW_BYTES;
  localparam int AW         = $clog2(MEM_BYTES);
  localparam int OFF_W      = $clog2(ROW_BYTES);
  localparam int RW         = AW - OFF_W;
  localparam int PB_W       = $clog2(PAGE_BYTES);
  localparam int PG_W       = $clog2(PAGES);
  localparam int DATA_BYTES = PAGES * PAGE_BYTES;
  localparam int CW         = $clog2(COPY_CYC + 1);

  scp_state_e           state;
  logic [7:0]           cmd_q, a1_q, a2_q, es_q;
  logic [15:0]          ta_q, ptr_q;
  logic [OFF_W-1:0]     off_q;
  logic                 full_q;
  logic [2:0]           ph_q;
  logic [CW-1:0]        cp_cnt;
  logic [RW-1:0]        cp_row_q;
  logic [ROW_BYTES-1:0] cp_mask_q, cp_mask_n;
  logic [7:0]           sp_q [ROW_BYTES];
  logic [8*ROW_BYTES-1:0] cp_data;
  logic [15:0]          crc;
  logic [7:0]           tx_next, mem_rd, wr_val, crc_din;
  logic [AW-1:0]        mem_raddr;
  logic [PG_W-1:0]      ta_page;
  logic [1:0]           ta_mode;
  logic                 ta_prot, ta_emul, ta_in_range, copy_ok, mem_we;
  logic                 rx_take, tx_take, crc_rx, crc_tx;

  // page mode of the stored target address
  assign ta_page     = ta_q[PB_W +: PG_W];
  assign ta_mode     = (int'(ta_q) < DATA_BYTES) ? page_mode[{ta_page, 1'b0} +: 2] : 2'b00;
  assign ta_prot     = ta_mode[0];
  assign ta_emul     = ta_mode[1] & ~ta_mode[0];
  assign ta_in_range = int'(ta_q) < MEM_BYTES;

  assign rx_take = rx_valid && !bus_reset;
  assign tx_take = tx_req && !bus_reset;

  assign mem_raddr = (state == S_MEM) ? ptr_q[AW-1:0] : {ta_q[AW-1:OFF_W], off_q};
  assign wr_val    = ta_emul ? (rx_data & mem_rd) : rx_data;
  assign copy_ok   = ({rx_data, a2_q, a1_q} == {es_q, ta_q}) && !es_q[ES_PF]
                     && ta_in_range && !ta_prot && (cp_cnt == '0);
  assign mem_we    = (cp_cnt == CW'(1));

  always_comb begin
    for (int b = 0; b < ROW_BYTES; b++) begin
      cp_mask_n[b]      = (OFF_W'(b) >= ta_q[OFF_W-1:0]) && (OFF_W'(b) <= es_q[OFF_W-1:0]);
      cp_data[8*b +: 8] = sp_q[b];
    end
  end

  always_comb begin
    tx_next = TX_IDLE;
    case (state)
      S_WR: if (full_q) begin
        if (ph_q == 3'd0)      tx_next = ~crc[7:0];
        else if (ph_q == 3'd1) tx_next = ~crc[15:8];
      end
      S_RD: case (ph_q)
        3'd0: tx_next = ta_q[7:0];
        3'd1: tx_next = ta_q[15:8];
        3'd2: tx_next = es_q;
        3'd3: tx_next = sp_q[off_q];
        3'd4: tx_next = ~crc[7:0];
        3'd5: tx_next = ~crc[15:8];
        default: tx_next = TX_IDLE;
      endcase
      S_CPY: tx_next = (cp_cnt != '0) ? TX_BUSY : TX_DONE;
      S_MEM: tx_next = (int'(ptr_q) < MEM_BYTES) ? mem_rd : TX_IDLE;
      default: tx_next = TX_IDLE;
    endcase
  end

  assign crc_rx  = rx_take && (state == S_CMD || state == S_TA1 || state == S_TA2 ||
                               (state == S_WR && !full_q));
  assign crc_tx  = tx_take && (state == S_RD) && (ph_q < 3'd4);
  assign crc_din = crc_rx ? rx_data : tx_next;

  scp_crc16 u_crc (
    .clk(clk), .rst(rst), .clr(bus_reset), .en(crc_rx || crc_tx), .din(crc_din), .crc(crc)
  );

  scp_mem_model #(.ROWS(ROWS), .ROW_BYTES(ROW_BYTES)) u_mem (
    .clk(clk), .we(mem_we && !rst), .wr_row(cp_row_q), .wr_mask(cp_mask_q),
    .wr_data(cp_data), .rd_addr(mem_raddr), .rd_data(mem_rd)
  );

  always_ff @(posedge clk) begin
    tx_valid <= 1'b0;
    if (rst) begin
      state <= S_CMD;  cmd_q <= '0;  a1_q <= '0;  a2_q <= '0;  es_q <= '0;
      ta_q  <= '0;     ptr_q <= '0;  off_q <= '0; full_q <= 1'b0; ph_q <= '0;
      cp_cnt <= '0;    cp_row_q <= '0; cp_mask_q <= '0; tx_data <= TX_IDLE;
      for (int b = 0; b < ROW_BYTES; b++) sp_q[b] <= '0;
    end else begin
      // copy engine runs regardless of bus activity
      if (cp_cnt != '0) begin
        cp_cnt <= cp_cnt - CW'(1);
        if (cp_cnt == CW'(1)) es_q[ES_AA] <= 1'b1;
      end
      if (bus_reset) begin
        state <= S_CMD;
        if (state == S_WR && bit_partial) es_q[ES_PF] <= 1'b1;
      end else begin
        if (rx_valid) begin
          case (state)
            S_CMD: begin
              cmd_q <= rx_data; ph_q <= '0; full_q <= 1'b0;
              if (rx_data == CMD_WRITE || rx_data == CMD_COPY || rx_data == CMD_MREAD)
                state <= S_TA1;
              else if (rx_data == CMD_READ) begin
                state <= S_RD; off_q <= ta_q[OFF_W-1:0];
              end else state <= S_TAIL;
            end
            S_TA1: begin a1_q <= rx_data; state <= S_TA2; end
            S_TA2: begin
              a2_q <= rx_data;
              if (cmd_q == CMD_WRITE) begin
                ta_q  <= {rx_data, a1_q};
                off_q <= a1_q[OFF_W-1:0];
                es_q  <= '0;
                es_q[OFF_W-1:0] <= a1_q[OFF_W-1:0];
                state <= S_WR;
              end else if (cmd_q == CMD_COPY) state <= S_ES;
              else begin
                ptr_q <= {rx_data, a1_q}; state <= S_MEM;
              end
            end
            S_ES: begin
              if (copy_ok) begin
                cp_cnt    <= CW'(COPY_CYC);
                cp_row_q  <= ta_q[AW-1:OFF_W];
                cp_mask_q <= cp_mask_n;
                state     <= S_CPY;
              end else state <= S_TAIL;
            end
            S_WR: if (!full_q) begin
              sp_q[off_q] <= wr_val;
              es_q[OFF_W-1:0] <= off_q;
              if (off_q == OFF_W'(ROW_BYTES - 1)) full_q <= 1'b1;
              else off_q <= off_q + 1'b1;
            end
            default: ;
          endcase
        end
        if (tx_req) begin
          tx_valid <= 1'b1;
          tx_data  <= tx_next;
          case (state)
            S_WR: if (full_q && ph_q != 3'd2) ph_q <= ph_q + 3'd1;
            S_RD: begin
              if (ph_q == 3'd3) begin
                if (off_q == OFF_W'(ROW_BYTES - 1)) ph_q <= 3'd4;
                else off_q <= off_q + 1'b1;
              end else if (ph_q != 3'd6) ph_q <= ph_q + 3'd1;
            end
            S_MEM: if (int'(ptr_q) < MEM_BYTES) ptr_q <= ptr_q + 16'd1;
            default: ;
          endcase
        end
      end
    end
  end

  AST_TX_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    tx_take |=> tx_valid); // R2
  AST_TX_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (rst)
    !tx_take |=> !tx_valid); // R2
  AST_NO_CRC_BEFORE_END: assert property (@(posedge clk) disable iff (rst)
    (tx_take && state == S_WR && !full_q) |=> (tx_data == TX_IDLE)); // R4
  AST_FULL_HOLDS_OFFSET: assert property (@(posedge clk) disable iff (rst)
    (state == S_WR && full_q && !bus_reset) |=> $stable(off_q)); // R4
  AST_PF_ON_CUT: assert property (@(posedge clk) disable iff (rst)
    (bus_reset && bit_partial && state == S_WR) |=> es_q[ES_PF]); // R11
  AST_BUSY_ANSWER: assert property (@(posedge clk) disable iff (rst)
    (tx_take && state == S_CPY && cp_cnt > CW'(1)) |=> (tx_data == TX_BUSY)); // R9
endmodule

// File: tb/scp_write_ctrl_tb.sv
module scp_write_ctrl_tb;
  localparam int COPY_CYC = 40;
  typedef logic [7:0] bq_t [$];

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_reset = 1'b0, bit_partial = 1'b0, rx_valid = 1'b0, tx_req = 1'b0;
  logic [7:0] rx_data = '0;
  logic [7:0] page_mode = '0;
  logic       tx_valid;
  logic [7:0] tx_data;

  always #2 clk = ~clk;

  scp_write_ctrl #(.COPY_CYC(COPY_CYC)) u_dut (
    .clk(clk), .rst(rst), .bus_reset(bus_reset), .bit_partial(bit_partial),
    .rx_valid(rx_valid), .rx_data(rx_data), .tx_req(tx_req), .page_mode(page_mode),
    .tx_valid(tx_valid), .tx_data(tx_data)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  function automatic logic [15:0] crc_of(input bq_t q);
    logic [15:0] c = 16'h0000;
    foreach (q[k])
      for (int i = 0; i < 8; i++)
        if (c[0] ^ q[k][i]) c = (c >> 1) ^ 16'hA001;
        else c = c >> 1;
    return c;
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic brst(input logic p);
    @(negedge clk); bus_reset = 1'b1; bit_partial = p;
    @(negedge clk); bus_reset = 1'b0; bit_partial = 1'b0;
  endtask

  // driver: queue the expectation, then request one byte
  task automatic pull(input logic [7:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); tx_req = 1'b1;
    @(negedge clk); tx_req = 1'b0;
  endtask

  task automatic pull_crc(input bq_t q, input string tag);
    logic [15:0] c;
    c = crc_of(q);
    pull(~c[7:0], tag);
    pull(~c[15:8], tag);
  endtask

  // monitor: pop and compare as the design answers
  always @(negedge clk) begin
    if (!rst && tx_valid) begin
      if (exp_q.size() == 0) begin
        n_run++; n_fail++;
        $display("FAIL R2: unexpected byte %02h expected none", tx_data);
      end else begin
        chk(tx_data, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({7'd0, tx_valid}, 8'h00, "R1 tx_valid idle");
    chk(tx_data, 8'hFF, "R1 tx_data idle");

    // R1: reset contents through read-back
    brst(0); put(8'hC3);
    pull(8'h00, "R1 ta1"); pull(8'h00, "R1 ta2"); pull(8'h00, "R1 es");
    for (int i = 0; i < 8; i++) pull(8'h00, "R1 row");
    pull_crc('{8'hC3, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
               8'h00, 8'h00, 8'h00, 8'h00}, "R5 read crc reset");

    // R2 R4 R5 R6: write from offset 3, extra byte ignored
    brst(0);
    put(8'h3C); put(8'h03); put(8'h00);
    put(8'h11); put(8'h22); put(8'h33); put(8'h44); put(8'h55); put(8'h66);
    pull_crc('{8'h3C, 8'h03, 8'h00, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55}, "R5 write crc");
    pull(8'hFF, "R6 after crc"); pull(8'hFF, "R6 after crc");
    brst(0); put(8'hC3);
    pull(8'h03, "R2 ta1"); pull(8'h00, "R2 ta2"); pull(8'h07, "R3 es end");
    pull(8'h11, "R2 d"); pull(8'h22, "R2 d"); pull(8'h33, "R2 d");
    pull(8'h44, "R2 d"); pull(8'h55, "R4 last byte kept");
    pull_crc('{8'hC3, 8'h03, 8'h00, 8'h07, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55},
             "R5 read crc");
    pull(8'hFF, "R6 tail");

    // R4 R3: short write, no crc before row end
    brst(0); put(8'h3C); put(8'h10); put(8'h00); put(8'hAA); put(8'hBB);
    pull(8'hFF, "R4 no crc early");
    brst(0); put(8'hC3);
    pull(8'h10, "R2 ta1"); pull(8'h00, "R2 ta2"); pull(8'h01, "R3 es short");
    pull(8'hAA, "R2 d0"); pull(8'hBB, "R2 d1"); pull(8'h00, "R2 old");
    pull(8'h11, "R2 old"); pull(8'h22, "R2 old");

    // R9 R12: good copy
    brst(0); put(8'h5A); put(8'h10); put(8'h00); put(8'h01);
    pull(8'h00, "R9 busy");
    repeat (COPY_CYC + 2) @(negedge clk);
    pull(8'hAA, "R9 done");
    brst(0); put(8'hA5); put(8'h10); put(8'h00);
    pull(8'hAA, "R12 mem"); pull(8'hBB, "R12 mem"); pull(8'hFF, "R9 masked");
    brst(0); put(8'hC3);
    pull(8'h10, "R9 ta1"); pull(8'h00, "R9 ta2"); pull(8'h81, "R9 es aa");

    // R10: mismatching status
    brst(0); put(8'h3C); put(8'h18); put(8'h00); put(8'h01); put(8'h02);
    brst(0); put(8'h5A); put(8'h18); put(8'h00); put(8'h02);
    pull(8'hFF, "R10 refused");
    brst(0); put(8'hA5); put(8'h18); put(8'h00);
    pull(8'hFF, "R10 unchanged"); pull(8'hFF, "R10 unchanged");

    // R11: partial byte at bus reset
    brst(0); put(8'h3C); put(8'h20); put(8'h00); put(8'h77);
    brst(1); put(8'hC3);
    pull(8'h20, "R11 ta1"); pull(8'h00, "R11 ta2"); pull(8'h20, "R11 pf");
    brst(0); put(8'h5A); put(8'h20); put(8'h00); put(8'h20);
    pull(8'hFF, "R10 pf refused");
    brst(0); put(8'hA5); put(8'h20); put(8'h00);
    pull(8'hFF, "R11 unchanged");

    // R7: one-way page 2
    brst(0); put(8'h3C); put(8'h40); put(8'h00); put(8'hF0); put(8'h0F);
    brst(0); put(8'h5A); put(8'h40); put(8'h00); put(8'h01);
    repeat (COPY_CYC + 2) @(negedge clk);
    pull(8'hAA, "R9 done p2");
    page_mode = 8'b0010_0000;
    brst(0); put(8'h3C); put(8'h40); put(8'h00); put(8'h3C); put(8'h3C);
    brst(0); put(8'hC3);
    pull(8'h40, "R7 ta1"); pull(8'h00, "R7 ta2"); pull(8'h01, "R7 es");
    pull(8'h30, "R7 and"); pull(8'h0C, "R7 and");
    brst(0); put(8'h5A); put(8'h40); put(8'h00); put(8'h01);
    repeat (COPY_CYC + 2) @(negedge clk);
    pull(8'hAA, "R7 copy");
    brst(0); put(8'hA5); put(8'h40); put(8'h00);
    pull(8'h30, "R7 mem"); pull(8'h0C, "R7 mem"); pull(8'hFF, "R7 mem");

    // R8: locked page 3
    page_mode = 8'b0110_0000;
    brst(0); put(8'h3C); put(8'h60); put(8'h00); put(8'h12);
    brst(0); put(8'h5A); put(8'h60); put(8'h00); put(8'h00);
    pull(8'hFF, "R8 refused");
    brst(0); put(8'hA5); put(8'h60); put(8'h00);
    pull(8'hFF, "R8 unchanged");

    // R9 R12: copy completes on the same edge as a bus reset
    brst(0); put(8'h3C); put(8'h88); put(8'h00);
    for (int i = 1; i <= 8; i++) put(8'(i));
    brst(0); put(8'h5A); put(8'h88); put(8'h00); put(8'h07);
    repeat (COPY_CYC - 2) @(negedge clk);
    brst(0);
    put(8'hA5); put(8'h8E); put(8'h00);
    pull(8'h07, "R9 same-cycle mem"); pull(8'h08, "R12 last addr");
    pull(8'hFF, "R12 past end"); pull(8'hFF, "R12 past end");
    brst(0); put(8'hC3);
    pull(8'h88, "R9 ta1"); pull(8'h00, "R9 ta2"); pull(8'h87, "R9 same-cycle aa");

    repeat (4) @(negedge clk);
    chk(8'(exp_q.size()), 8'h00, "R2 all answered");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule